// File: doc/BRIEF.md
# Asynchronous External Memory Bridge

This block is an AHB-Lite slave that lets the on-chip bus reach SRAM or NOR flash parts that have no clock. It claims a fixed 128 MB address window and splits it into two 64 MB banks, each with its own active-low chip select. The external side has a shared data path, strapped to 8 or 16 bits, with active-low output enable, write enable and per-lane byte enables. The byte enables can act as the write strobes of byte-wide parts.

Each single AHB transfer of a byte, half-word or word becomes one or more narrow external beats. The lowest address goes first. Unaligned start addresses are resolved into the correct external addresses and lanes. Every beat has one address-setup cycle and then a strobe window. The length of that window comes from the wait setting of the bank being accessed. The AHB data phase is held with HREADYOUT low until the last beat completes. Read bytes are gathered into a 32-bit holding register and presented on HRDATA in the cycle that HREADYOUT rises.

Top module: `amem_ctrl`

## Requirements
- R1: A transfer is started only when hsel, hready and htrans = 2'b10 (NONSEQ) are all true and haddr[31:27] = 5'b01110, which is the window 0x70000000–0x77FFFFFF. Any other address causes no chip select and no wait state.
- R2: haddr[26] picks the bank. Bank 0 drives mem_cs_n[0] low and bank 1 drives mem_cs_n[1] low. The two selects are never low together.
- R3: With cfg_wide = 0 (8-bit bus), a transfer of 2^hsize bytes becomes one beat per byte. Beat k puts haddr[25:0]+k on mem_addr and has mem_be_n = 2'b10.
- R4: With cfg_wide = 1 (16-bit bus), there is one beat for each half-word that the byte range touches, taken in ascending order. mem_addr is byte address >> 1. mem_be_n[L] is low only for the lanes L (the byte address bit 0) that lie inside the range.
- R5: Byte k of a transfer (k = 0 is at haddr) travels in AHB lane (haddr[1:0]+k) mod 4 of HWDATA and HRDATA. This holds for unaligned addresses too.
- R6: Each beat lasts 1 setup cycle plus max(W,1) strobe cycles. HREADYOUT stays low for the sum over all beats and rises in the next cycle, so a single beat with W = 2 gives three wait states.
- R7: W is cfg_wait0 for bank 0 and cfg_wait1 for bank 1, chosen independently.
- R8: On a write, mem_we_n and the enabled mem_be_n lanes are low only in strobe cycles. mem_dq_oe is high only then, and mem_dq_o carries the transfer bytes on their lanes. Bytes outside the range are not written.
- R9: On a read, mem_oe_n is low in strobe cycles. The bytes sampled at the end of each beat appear on HRDATA when HREADYOUT rises, and AHB lanes outside the range read as zero.
- R10: mem_oe_n and mem_we_n are never low at the same time, and a strobe is low only while a chip select is low.
- R11: After reset, hreadyout = 1, both chip selects are high, mem_oe_n = mem_we_n = 1, mem_be_n = 2'b11 and mem_dq_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | AHB address |
| htrans | input | 2 | Transfer type; only NONSEQ is served |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size, log2 bytes |
| hwdata | input | 32 | Write data |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | Slave ready, low during wait states |
| hresp | output | 1 | Always OKAY |
| hrdata | output | 32 | Read data |
| cfg_wide | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| cfg_wait0 | input | 4 | Strobe cycles for bank 0 |
| cfg_wait1 | input | 4 | Strobe cycles for bank 1 |
| mem_cs_n | output | 2 | Bank chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Lane byte enables, active low |
| mem_addr | output | 26 | External address |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
The bench sweeps both bus widths, both banks, all three sizes, all four start offsets, and reads and writes. The wait settings differ per bank and rotate through 0–3. The offsets tell apart correct half-word grouping and wrong half-word grouping, and they also tell correct lane rotation from naive aligned placement. A word at offset 3 on the 16-bit bus needs three beats with a lone upper lane, then a lone lower lane. Byte reads at every offset show whether unused AHB lanes are cleared. Writes to the bytes around each range show whether any stray strobe reaches memory. Addresses just outside both ends of the window confirm that nothing is selected there.

// File: rtl/amem_pkg.sv
// Shared types for the asynchronous memory bridge.
package amem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_DONE   = 2'd3
    } amem_state_e;

    localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
endpackage

// File: rtl/amem_beat_plan.sv
// Works out the lanes and the byte count of the next external beat.
// Assumes remain >= 1. On the 8-bit bus only lane 0 is used. On the
// 16-bit bus the beat covers the half-word that holds the current byte.
module amem_beat_plan (
    input  logic       wide,
    input  logic       cur_lsb,
    input  logic [2:0] remain,
    output logic [1:0] lane_en,
    output logic [1:0] take
);
    // Choose the lanes for this beat and count them
    always_comb begin
        if (wide) begin
            lane_en[0] = !cur_lsb;
            lane_en[1] = cur_lsb || (remain >= 3'd2);
        end else begin
            lane_en = 2'b01;
        end
        take = {1'b0, lane_en[0]} + {1'b0, lane_en[1]};
    end
endmodule

// File: rtl/amem_seq.sv
// Beat sequencer: one setup cycle, then max(wait_cfg,1) strobe cycles per
// beat, then a single completion cycle. A new transfer is accepted only
// in idle or completion. Assumes wait_cfg is static while a transfer runs.
module amem_seq import amem_pkg::*; #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              last_beat,
    output amem_state_e       st,
    output logic              beat_end
);
    logic [WAIT_W-1:0] wcnt;

    assign beat_end = (st == ST_ACCESS) && (wcnt == '0);

    // State and strobe counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            wcnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE: st <= start ? ST_SETUP : ST_IDLE;
                ST_SETUP: begin
                    st   <= ST_ACCESS;
                    wcnt <= (wait_cfg == '0) ? '0 : wait_cfg - 1'b1;
                end
                ST_ACCESS: begin
                    if (wcnt == '0) st <= last_beat ? ST_DONE : ST_SETUP;
                    else            wcnt <= wcnt - 1'b1;
                end
            endcase
        end
    end

    // R6: setup always hands over to the strobe window
    assert_setup_then_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETUP) |=> (st == ST_ACCESS));
    // R6: completion lasts exactly one cycle
    assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |=> (st != ST_DONE));
endmodule

// File: rtl/amem_ctrl.sv
// AHB-Lite slave bridging single transfers to an asynchronous parallel
// memory with two banks. Assumes a single-slave HREADY loop or correct
// bus muxing, hwdata held stable through the data phase (as AHB
// requires), and static cfg_* straps.
module amem_ctrl import amem_pkg::*; #(
    parameter int EXT_AW = 26,
    parameter int WAIT_W = 4,
    parameter logic [30-EXT_AW:0] WIN_TAG = 5'b01110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [31:0]       haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [31:0]       hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic              hresp,
    output logic [31:0]       hrdata,
    input  logic              cfg_wide,
    input  logic [WAIT_W-1:0] cfg_wait0,
    input  logic [WAIT_W-1:0] cfg_wait1,
    output logic [1:0]        mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_be_n,
    output logic [EXT_AW-1:0] mem_addr,
    output logic [15:0]       mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_i
);
    localparam int BANK_BIT = EXT_AW;
    localparam int LANES    = 2;

    amem_state_e       st;
    logic              beat_end, start, in_win, last_beat;
    logic              ctx_bank, ctx_wr;
    logic [1:0]        ctx_off;
    logic [EXT_AW-1:0] cur;
    logic [2:0]        remain, done_n, size_bytes;
    logic [31:0]       rdbuf;
    logic [1:0]        lane_en, take;
    logic [1:0]        lidx [LANES];
    logic              busy, strobe;

    assign in_win = (haddr[31:BANK_BIT+1] == WIN_TAG);
    assign start  = hsel && hready && (htrans == HTRANS_NONSEQ) && in_win &&
                    ((st == ST_IDLE) || (st == ST_DONE));
    assign size_bytes = (hsize[2] || hsize[1]) ? 3'd4 : (hsize[0] ? 3'd2 : 3'd1);

    amem_beat_plan plan_i (
        .wide    (cfg_wide),
        .cur_lsb (cur[0]),
        .remain  (remain),
        .lane_en (lane_en),
        .take    (take)
    );

    assign last_beat = (remain <= {1'b0, take});

    amem_seq #(.WAIT_W(WAIT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wait_cfg  (ctx_bank ? cfg_wait1 : cfg_wait0),
        .last_beat (last_beat),
        .st        (st),
        .beat_end  (beat_end)
    );

    // AHB lane of the byte carried on each external lane in this beat
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lidx[l] = ctx_off + done_n[1:0] + 2'(l) - ((cfg_wide) ? {1'b0, cur[0]} : 2'b00);
        end
    end

    // Transfer context: capture at start, advance after each beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_bank <= 1'b0;
            ctx_wr   <= 1'b0;
            ctx_off  <= '0;
            cur      <= '0;
            remain   <= '0;
            done_n   <= '0;
            rdbuf    <= '0;
        end else if (start) begin
            ctx_bank <= haddr[BANK_BIT];
            ctx_wr   <= hwrite;
            ctx_off  <= haddr[1:0];
            cur      <= haddr[EXT_AW-1:0];
            remain   <= size_bytes;
            done_n   <= '0;
            rdbuf    <= '0;
        end else if (beat_end) begin
            cur    <= cur + EXT_AW'(take);
            remain <= remain - {1'b0, take};
            done_n <= done_n + {1'b0, take};
            if (!ctx_wr) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_en[l]) rdbuf[8*lidx[l] +: 8] <= mem_dq_i[8*l +: 8];
                end
            end
        end
    end

    assign busy   = (st == ST_SETUP) || (st == ST_ACCESS);
    assign strobe = (st == ST_ACCESS);

    // External pin drive
    always_comb begin
        mem_cs_n[0] = !(busy && !ctx_bank);
        mem_cs_n[1] = !(busy && ctx_bank);
        mem_oe_n    = !(strobe && !ctx_wr);
        mem_we_n    = !(strobe && ctx_wr);
        mem_dq_oe   = strobe && ctx_wr;
        for (int l = 0; l < LANES; l++) begin
            mem_be_n[l]       = !(strobe && lane_en[l]);
            mem_dq_o[8*l +: 8] = (cfg_wide || l == 0) ? hwdata[8*lidx[l] +: 8] : 8'h00;
        end
        mem_addr = cfg_wide ? {1'b0, cur[EXT_AW-1:1]} : cur;
    end

    assign hreadyout = !busy;
    assign hresp     = 1'b0;
    assign hrdata    = rdbuf;

    // R10: output and write enables never overlap
    assert_oe_we_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    // R10: a strobe only inside a selected bank
    assert_strobe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != 2'b11));
    // R2: at most one bank selected
    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
    // R8: the data driver is on only while writing
    assert_drive_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);
    // R6: the AHB side waits while an external access is in flight
    assert_wait_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != 2'b11) |-> !hreadyout);
    // R4: the address holds steady through a strobe window
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) && $past(!mem_oe_n || !mem_we_n) |-> $stable(mem_addr));
endmodule

// File: tb/amem_ctrl_tb_top.sv
module amem_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0, hwrite = 1'b0;
    logic [31:0] haddr = '0, hwdata = '0;
    logic [1:0]  htrans = '0;
    logic [2:0]  hsize = '0;
    logic        hreadyout, hresp;
    logic [31:0] hrdata;
    logic        cfg_wide = 1'b0;
    logic [3:0]  cfg_wait0 = 4'd2, cfg_wait1 = 4'd2;
    logic [1:0]  mem_cs_n, mem_be_n;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [25:0] mem_addr;
    logic [15:0] mem_dq_o, mem_dq_i = '0;

    int checks = 0, fails = 0, viol = 0;
    bit finished = 0;
    logic [7:0] mem [2][4096];
    int nlog, cs_seen;
    int log_addr [8], log_ben [8], log_bank [8];

    always #2.5 clk = ~clk;

    amem_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hreadyout),
        .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
        .cfg_wide(cfg_wide), .cfg_wait0(cfg_wait0), .cfg_wait1(cfg_wait1),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [7:0] pat(int bank, int a);
        return 8'((a * 7) ^ (bank * 8'h3C) ^ 8'h5A);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model the memory and log beats at one negedge
    task automatic sample(inout bit prev_act);
        bit act;
        int bank, idx;
        act  = !mem_oe_n || !mem_we_n;
        bank = mem_cs_n[1] ? 0 : 1;
        if (mem_cs_n != 2'b11) cs_seen = 1;
        if (mem_cs_n == 2'b00) viol++;
        if (!mem_oe_n && !mem_we_n) viol++;
        if (mem_dq_oe && mem_we_n) viol++;
        if (act && mem_cs_n == 2'b11) viol++;
        if (act && !prev_act && nlog < 8) begin
            log_addr[nlog] = int'(mem_addr);
            log_ben[nlog]  = int'(mem_be_n);
            log_bank[nlog] = bank;
            nlog++;
        end
        mem_dq_i = '0;
        for (int l = 0; l < 2; l++) begin
            idx = (cfg_wide ? ((int'(mem_addr) << 1) | l) : int'(mem_addr)) & 12'hFFF;
            if (act && !mem_be_n[l] && (cfg_wide || l == 0)) begin
                if (!mem_we_n) mem[bank][idx] = mem_dq_o[8*l +: 8];
                if (!mem_oe_n) mem_dq_i[8*l +: 8] = mem[bank][idx];
            end
        end
        prev_act = act;
    endtask

    task automatic xfer(input logic [31:0] a, input logic [2:0] sz, input logic wr,
                        input logic [31:0] wd, output logic [31:0] rd, output int waits);
        bit prev_act;
        nlog = 0; cs_seen = 0; prev_act = 0;
        @(negedge clk);
        hsel = 1; htrans = 2'b10; haddr = a; hwrite = wr; hsize = sz;
        @(posedge clk);
        @(negedge clk);
        hsel = 0; htrans = 2'b00; hwdata = wd; waits = 0;
        while (!hreadyout) begin
            waits++;
            sample(prev_act);
            @(negedge clk);
        end
        rd = hrdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int idx, n, w, eb, wexp, prevh, h, off26, lane;
        int ea [8], eben [8];
        logic [31:0] a, wd, rd, erd;
        int waits;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 4096; i++) mem[b][i] = pat(b, i);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset values
        check(hreadyout === 1'b1, "R11 hreadyout", int'(hreadyout), 1);
        check(mem_cs_n === 2'b11, "R11 cs_n", int'(mem_cs_n), 3);
        check(mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R11 oe/we", int'({mem_oe_n, mem_we_n}), 3);
        check(mem_be_n === 2'b11 && mem_dq_oe === 1'b0, "R11 be/dq_oe", int'({mem_be_n, mem_dq_oe}), 6);
        rst_n = 1'b1;

        // R1: addresses just outside the window
        xfer(32'h6FFF_FFFC, 3'd2, 1'b0, 32'h0, rd, waits);
        check(waits == 0 && cs_seen == 0, "R1 below window", waits, 0);
        xfer(32'h7800_0000, 3'd2, 1'b1, 32'h1234_5678, rd, waits);
        check(waits == 0 && cs_seen == 0, "R1 above window", waits, 0);

        idx = 0;
        for (int wide = 0; wide < 2; wide++)
        for (int bank = 0; bank < 2; bank++)
        for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
        for (int wr = 0; wr < 2; wr++) begin
            idx++;
            cfg_wide  = wide[0];
            cfg_wait0 = 4'(idx % 4);
            cfg_wait1 = 4'((idx + 1) % 4);
            w = bank ? int'(cfg_wait1) : int'(cfg_wait0);
            if (w == 0) w = 1;
            n = 1 << sz;
            off26 = (idx[0] ? 26'h3FF_F000 : 0) + ((idx * 16) & 12'hFF0) + off;
            a = 32'h7000_0000 | (32'(bank) << 26) | 32'(off26);
            wd = 32'hA500_0000 ^ (32'(idx) * 32'h0103_0507);
            for (int k = -1; k <= n; k++) mem[bank][(off26 + k) & 12'hFFF] = pat(bank, (off26 + k) & 12'hFFF);

            // expected beat list
            eb = 0; prevh = -1;
            for (int k = 0; k < n; k++) begin
                if (!wide) begin
                    ea[eb] = off26 + k; eben[eb] = 2; eb++;
                end else begin
                    h = (off26 + k) >> 1;
                    if (h != prevh) begin ea[eb] = h; eben[eb] = 3; eb++; prevh = h; end
                    eben[eb-1] = eben[eb-1] & ~(1 << ((off26 + k) & 1));
                end
            end
            wexp = eb * (1 + w);

            xfer(a, 3'(sz), wr[0], wd, rd, waits);

            check(waits == wexp, "R6/R7 wait states", waits, wexp);
            check(nlog == eb, wide ? "R4 beat count" : "R3 beat count", nlog, eb);
            for (int j = 0; j < eb && j < nlog; j++) begin
                check(log_addr[j] == ea[j], wide ? "R4 beat address" : "R3 beat address", log_addr[j], ea[j]);
                check(log_ben[j] == eben[j], wide ? "R4 byte enables" : "R3 byte enables", log_ben[j], eben[j]);
                check(log_bank[j] == bank, "R2 bank select", log_bank[j], bank);
            end
            if (wr) begin
                for (int k = 0; k < n; k++) begin
                    lane = (off + k) % 4;
                    check(mem[bank][(off26 + k) & 12'hFFF] == wd[8*lane +: 8], "R5/R8 written byte",
                          int'(mem[bank][(off26 + k) & 12'hFFF]), int'(wd[8*lane +: 8]));
                end
                check(mem[bank][(off26 - 1) & 12'hFFF] == pat(bank, (off26 - 1) & 12'hFFF), "R8 byte below untouched",
                      int'(mem[bank][(off26 - 1) & 12'hFFF]), int'(pat(bank, (off26 - 1) & 12'hFFF)));
                check(mem[bank][(off26 + n) & 12'hFFF] == pat(bank, (off26 + n) & 12'hFFF), "R8 byte above untouched",
                      int'(mem[bank][(off26 + n) & 12'hFFF]), int'(pat(bank, (off26 + n) & 12'hFFF)));
            end else begin
                erd = '0;
                for (int k = 0; k < n; k++) erd[8*((off + k) % 4) +: 8] = pat(bank, (off26 + k) & 12'hFFF);
                check(rd == erd, "R5/R9 read data", int'(rd), int'(erd));
            end
        end

        // R10: strobe and select rules over the whole run
        check(viol == 0, "R10 strobe rules", viol, 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule